// File: doc/BRIEF.md
# Serial Flash Range Erase Sequencer

This block erases a byte range of a paged serial flash device. It talks to a byte-wide SPI transaction port: a chip-select output, a transmit byte with a valid/ready handshake, and the byte received during each exchange. A single start pulse supplies the start offset, the length in bytes, the page size in bytes and the page-address shift. When the block finishes, it reports either done or error.

The block first checks that the range is page aligned. It does this with two serial dividers, so page sizes that are not a power of two (for example 264 or 528 bytes) work. It then walks the range one page index at a time. Where the current index is a multiple of eight and at least eight pages remain, it issues one eight-page block erase; otherwise it issues a single-page erase. After every erase command it reads the device status repeatedly until the ready flag is set. A cycle counter bounds this polling.

The port contract is as follows. A byte exchange completes in a cycle where both `tx_valid` and `tx_ready` are high. In that same cycle, `rx_byte` carries the byte received during the exchange.

Top module: `flash_erase_seq`

## Requirements
- R1: A request is rejected with `error`, and with no SPI traffic, when the offset or the length is not an exact multiple of the page size, or when the page size is zero.
- R2: The erase opcode is 0x50 (eight-page block) when the current page index has bits 2:0 equal to zero and at least eight pages remain. Otherwise the opcode is 0x81 (single page).
- R3: Each erase command is exactly four bytes: the opcode, bits 23:16 of the shifted page address, bits 15:8 of it, and 0x00. A byte offered on `tx_byte` stays unchanged until it is accepted.
- R4: The shifted page address is the page index (offset divided by page size, then advanced) shifted left by `page_shift`.
- R5: After each erase command, status transactions of two bytes (0xD7, then a dummy 0x00) repeat until bit 7 of the byte received during the second exchange is 1. No other bit of that byte affects the result.
- R6: The page index advances by 8 after a block erase and by 1 after a page erase. `done` is raised when the remaining page count reaches zero.
- R7: `spi_cs_n` is low only for the bytes of one transaction. It is high for at least one cycle between transactions and whenever the block is idle.
- R8: If the status has not reported ready within `TIMEOUT_CYCLES` cycles of polling for one command, the block raises `error`, issues no further command and returns to idle.
- R9: A start with zero length raises `done` without any SPI traffic. `done` and `error` are never high together, and each holds until the next accepted start.
- R10: `start` is ignored while `busy` is high. The commands issued are those of the first request only.
- R11: After reset, `busy`, `done`, `error` and `tx_valid` are 0 and `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| offset | input | ADDR_W | Start byte offset of the range |
| length | input | ADDR_W | Range length in bytes |
| page_size | input | PS_W | Page size in bytes |
| page_shift | input | SH_W | Left shift from page index to device page address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last request finished successfully |
| error | output | 1 | Last request rejected or timed out |
| spi_cs_n | output | 1 | Chip select, active low |
| tx_valid | output | 1 | Transmit byte offered |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Port accepts the offered byte |
| rx_byte | input | 8 | Byte received during the accepted exchange |

## Verification
The bench targets several corner cases.

- **Block/page choice.** It uses ranges that begin a few pages before an eight-page boundary with 264-byte pages. A design that tested the range start, rather than the current index, would pick the wrong erase type. Such a design would send a block opcode at an unaligned page or miss the block at the boundary.
- **Address bits.** It uses a high page index so that address bits 23:16 are non-zero. A wrong shift or byte order would show up as corrupted address bytes.
- **Status decoding.** Not-ready status bytes carry other bits set. A design that tested the whole byte, rather than bit 7, would move on too early.
- **Rejects, timeouts and overlapping starts.** Misaligned requests, a device that never becomes ready, and a start during a run must produce no traffic, no further command and no change in commands, respectively.

// File: rtl/flash_erase_pkg.sv
// Shared opcodes and sequencer state encoding for the range erase sequencer.
// Assumes a device taking a 3-byte page address after each erase opcode.
package flash_erase_pkg;
    localparam logic [7:0] OP_ERASE_BLOCK = 8'h50;
    localparam logic [7:0] OP_ERASE_PAGE  = 8'h81;
    localparam logic [7:0] OP_STATUS      = 8'hD7;
    localparam int unsigned BLOCK_PAGES   = 8;
    localparam int unsigned CMD_AW        = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_CMD,
        S_GAP_POLL,
        S_POLL,
        S_GAP_CMD
    } seq_state_t;
endpackage

// File: rtl/erase_divider.sv
// Serial restoring divider: one quotient bit per cycle, N cycles per division.
// Assumes a non-zero divisor; the divisor is captured at load so the caller may change it.
module erase_divider #(
    parameter int N   = 24,
    parameter int D_W = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [N-1:0]   dividend,
    input  logic [D_W-1:0] divisor,
    output logic           running,
    output logic [N-1:0]   quotient,
    output logic [N-1:0]   remainder
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]   rem_q;
    logic [N-1:0]   quo_q;
    logic [D_W-1:0] div_q;
    logic [CW-1:0]  cnt_q;
    logic           run_q;
    logic [N:0]     rem_sh;
    logic           fits;

    // Trial subtraction for the next quotient bit.
    always_comb begin
        rem_sh = {rem_q, quo_q[N-1]};
        fits   = rem_sh >= (N+1)'(div_q);
    end

    // Shift-and-subtract iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            div_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            div_q <= divisor;
            cnt_q <= CW'(N);
            run_q <= 1'b1;
        end else if (run_q) begin
            rem_q <= fits ? N'(rem_sh - (N+1)'(div_q)) : N'(rem_sh);
            quo_q <= {quo_q[N-2:0], fits};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) run_q <= 1'b0;
        end
    end

    assign running   = run_q;
    assign quotient  = quo_q;
    assign remainder = rem_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(run_q) && div_q != '0) |-> (rem_q < N'(div_q))); // R1
endmodule

// File: rtl/erase_timer.sv
// Saturating cycle counter used to bound status polling.
// Counts while clear is low; expired stays high once LIMIT is reached.
module erase_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count polling cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)           cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == CW'(LIMIT));

    AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && $past(expired)) |-> expired); // R8
endmodule

// File: rtl/flash_erase_seq.sv
// Range erase sequencer: validates alignment, walks pages choosing block or
// page erase, polls device status after each command, reports done/error.
// Assumes a byte-level SPI port where valid&ready completes one exchange and
// rx_byte holds the byte received in that same cycle.
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W         = 24,
    parameter int PS_W           = 12,
    parameter int SH_W           = 4,
    parameter int TIMEOUT_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] length,
    input  logic [PS_W-1:0]   page_size,
    input  logic [SH_W-1:0]   page_shift,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              spi_cs_n,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    input  logic [7:0]        rx_byte
);
    seq_state_t         state_q;
    logic [ADDR_W-1:0]  pg_q;
    logic [ADDR_W-1:0]  left_q;
    logic [SH_W-1:0]    sh_q;
    logic [1:0]         bcnt_q;
    logic               done_q;
    logic               err_q;

    logic               hs;
    logic               use_blk;
    logic [ADDR_W-1:0]  step;
    logic [CMD_AW-1:0]  sh_addr;
    logic               div_load;
    logic               off_run;
    logic               len_run;
    logic [ADDR_W-1:0]  off_quo;
    logic [ADDR_W-1:0]  off_rem;
    logic [ADDR_W-1:0]  len_quo;
    logic [ADDR_W-1:0]  len_rem;
    logic               tmo;
    logic               unused_bits;

    // Page index and page count by serial division.
    erase_divider #(.N(ADDR_W), .D_W(PS_W)) u_div_off (
        .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(offset),
        .divisor(page_size), .running(off_run), .quotient(off_quo), .remainder(off_rem));

    erase_divider #(.N(ADDR_W), .D_W(PS_W)) u_div_len (
        .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(length),
        .divisor(page_size), .running(len_run), .quotient(len_quo), .remainder(len_rem));

    erase_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(!(state_q == S_POLL || state_q == S_GAP_POLL)),
        .expired(tmo));

    // Erase type, step size and command address for the current page.
    always_comb begin
        hs       = tx_valid && tx_ready;
        use_blk  = (pg_q[2:0] == 3'd0) && (left_q >= ADDR_W'(BLOCK_PAGES));
        step     = use_blk ? ADDR_W'(BLOCK_PAGES) : ADDR_W'(1);
        sh_addr  = CMD_AW'(pg_q << sh_q);
        div_load = (state_q == S_IDLE) && start && (length != '0) && (page_size != '0);
    end

    assign unused_bits = ^{sh_addr[7:0], rx_byte[6:0]};

    // Byte mux for the erase command and the status poll.
    always_comb begin
        tx_byte = 8'h00;
        if (state_q == S_CMD) begin
            unique case (bcnt_q)
                2'd0:    tx_byte = use_blk ? OP_ERASE_BLOCK : OP_ERASE_PAGE;
                2'd1:    tx_byte = sh_addr[23:16];
                2'd2:    tx_byte = sh_addr[15:8];
                default: tx_byte = 8'h00;
            endcase
        end else if (state_q == S_POLL && bcnt_q == 2'd0) begin
            tx_byte = OP_STATUS;
        end
    end

    assign tx_valid = (state_q == S_CMD) || (state_q == S_POLL);
    assign spi_cs_n = !tx_valid;
    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign error    = err_q;

    // Sequencer: accept, divide, command, poll, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pg_q    <= '0;
            left_q  <= '0;
            sh_q    <= '0;
            bcnt_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    done_q <= (length == '0);
                    err_q  <= (length != '0) && (page_size == '0);
                    sh_q   <= page_shift;
                    if (div_load) state_q <= S_DIV;
                end
                S_DIV: if (!off_run && !len_run) begin
                    if (off_rem != '0 || len_rem != '0) begin
                        err_q   <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        pg_q    <= off_quo;
                        left_q  <= len_quo;
                        bcnt_q  <= '0;
                        state_q <= S_CMD;
                    end
                end
                S_CMD: if (hs) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q == 2'd3) begin
                        bcnt_q  <= '0;
                        state_q <= S_GAP_POLL;
                    end
                end
                S_GAP_POLL: begin
                    if (tmo) begin
                        err_q   <= 1'b1;
                        state_q <= S_IDLE;
                    end else begin
                        state_q <= S_POLL;
                    end
                end
                S_POLL: if (hs) begin
                    bcnt_q <= bcnt_q + 1'b1;
                    if (bcnt_q == 2'd1) begin
                        bcnt_q <= '0;
                        if (!rx_byte[7]) begin
                            state_q <= S_GAP_POLL;
                        end else if (left_q == step) begin
                            left_q  <= '0;
                            done_q  <= 1'b1;
                            state_q <= S_IDLE;
                        end else begin
                            pg_q    <= pg_q + step;
                            left_q  <= left_q - step;
                            state_q <= S_GAP_CMD;
                        end
                    end
                end
                S_GAP_CMD: state_q <= S_CMD;
                default:   state_q <= S_IDLE;
            endcase
        end
    end

    AST_HOLD_OFFERED_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R3

    AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && ((state_q == S_CMD && bcnt_q == 2'd3) || (state_q == S_POLL && bcnt_q == 2'd1)))
        |=> spi_cs_n); // R7

    AST_PAGES_NEVER_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) != S_IDLE && $past(state_q) != S_DIV && state_q != S_IDLE)
        |-> (left_q <= $past(left_q))); // R6

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n); // R7
endmodule

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
    localparam int ADDR_W = 24;
    localparam int PS_W   = 12;
    localparam int SH_W   = 4;
    localparam int TMO    = 300;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] offset = '0;
    logic [ADDR_W-1:0] length = '0;
    logic [PS_W-1:0]   page_size = '0;
    logic [SH_W-1:0]   page_shift = '0;
    logic              busy, done, error, spi_cs_n, tx_valid;
    logic [7:0]        tx_byte;
    logic              tx_ready = 1'b0;
    logic [7:0]        rx_byte = 8'h00;

    flash_erase_seq #(.ADDR_W(ADDR_W), .PS_W(PS_W), .SH_W(SH_W), .TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .length(length),
        .page_size(page_size), .page_shift(page_shift), .busy(busy), .done(done),
        .error(error), .spi_cs_n(spi_cs_n), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .tx_ready(tx_ready), .rx_byte(rx_byte));

    always #10 clk = ~clk; // 50 MHz

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    logic [31:0] exp_q[$];
    logic [7:0]  txn[8];
    int  tlen = 0;
    int  polls_left = 0;
    int  busy_polls = 0;
    bit  never_ready = 1'b0;
    int  stat_cnt = 0;
    int  txn_cnt = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Driver side: expected erase commands from the requirement rules.
    task automatic plan_range(input int off, input int len, input int ps, input int sh);
        int pg = off / ps;
        int n = len / ps;
        while (n > 0) begin
            bit blk = (pg % 8 == 0) && (n >= 8);
            int a = pg << sh;
            exp_q.push_back({blk ? 8'h50 : 8'h81, 8'(a >> 16), 8'(a >> 8), 8'h00});
            pg += blk ? 8 : 1;
            n  -= blk ? 8 : 1;
        end
    endtask

    // Monitor: close a finished transaction and score it.
    task automatic close_txn();
        txn_cnt++;
        if (txn[0] == 8'hD7) begin
            stat_cnt++;
            chk(tlen == 2 && txn[1] == 8'h00, "R5", "status transaction length/dummy", tlen, 2);
        end else begin
            logic [31:0] got;
            got = {txn[0], txn[1], txn[2], txn[3]};
            chk(tlen == 4, "R7", "erase transaction byte count", tlen, 4);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected extra erase command", got, 0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(got == e, "R3", "erase command bytes (R2 opcode, R4 address)", got, e);
            end
            polls_left = busy_polls;
        end
    endtask

    // Device model: accept a byte every other cycle, answer status polls.
    always @(negedge clk) begin
        if (!rst_n) begin
            tx_ready = 1'b0;
            tlen = 0;
        end else begin
            if (tx_ready) begin
                tx_ready = 1'b0;
            end else if (tx_valid && !spi_cs_n) begin
                if (tlen < 8) txn[tlen] = tx_byte;
                tlen++;
                if (tlen == 2 && txn[0] == 8'hD7) begin
                    if (never_ready)         rx_byte = 8'h7F;
                    else if (polls_left > 0) begin polls_left--; rx_byte = 8'h7F; end
                    else                     rx_byte = 8'h80;
                end else begin
                    rx_byte = 8'h00;
                end
                tx_ready = 1'b1;
            end
            if (spi_cs_n && tlen > 0) begin
                close_txn();
                tlen = 0;
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
                summary();
                $finish;
            end
        end
    end

    task automatic pulse_start(input int off, input int len, input int ps, input int sh);
        @(negedge clk);
        offset = ADDR_W'(off);
        length = ADDR_W'(len);
        page_size = PS_W'(ps);
        page_shift = SH_W'(sh);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_op(input int off, input int len, input int ps, input int sh);
        pulse_start(off, len, ps, sh);
        wait_idle();
    endtask

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(busy == 1'b0 && done == 1'b0 && error == 1'b0, "R11", "flags after reset",
            {busy, done, error}, 0);
        chk(spi_cs_n == 1'b1 && tx_valid == 1'b0, "R11", "port after reset",
            {spi_cs_n, tx_valid}, 2);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R6: 256-byte pages, block then two pages
        plan_range(0, 256 * 10, 256, 8);
        run_op(0, 256 * 10, 256, 8);
        chk(done && !error, "R6", "done after 10 pages", {done, error}, 2);
        chk(exp_q.size() == 0, "R6", "all commands issued", exp_q.size(), 0);

        // R5: 264-byte pages around a block boundary with busy polls
        busy_polls = 3;
        stat_cnt = 0;
        plan_range(264 * 3, 264 * 14, 264, 9);
        run_op(264 * 3, 264 * 14, 264, 9);
        chk(done && !error, "R2", "done after mixed page/block walk", {done, error}, 2);
        chk(stat_cnt == 28, "R5", "status polls for 7 commands x 4", stat_cnt, 28);
        chk(exp_q.size() == 0, "R2", "mixed walk commands issued", exp_q.size(), 0);

        // R4: high page index, bits 23:16 non-zero; 528-byte pages shift 10
        busy_polls = 0;
        plan_range(256 * 504, 256 * 8, 256, 8);
        run_op(256 * 504, 256 * 8, 256, 8);
        chk(done && exp_q.size() == 0, "R4", "block at page 504", exp_q.size(), 0);
        plan_range(528 * 16, 528 * 9, 528, 10);
        run_op(528 * 16, 528 * 9, 528, 10);
        chk(done && exp_q.size() == 0, "R4", "528-byte pages", exp_q.size(), 0);

        // R1: misaligned offset, misaligned length, zero page size
        t0 = txn_cnt;
        run_op(100, 256 * 2, 256, 8);
        chk(error && !done, "R1", "misaligned offset rejected", {done, error}, 1);
        run_op(264, 300, 264, 9);
        chk(error && !done, "R1", "misaligned length rejected", {done, error}, 1);
        run_op(0, 256, 0, 8);
        chk(error && !done, "R1", "zero page size rejected", {done, error}, 1);
        chk(txn_cnt == t0, "R1", "no traffic on reject", txn_cnt - t0, 0);

        // R9: zero length
        run_op(12345, 0, 256, 8);
        chk(done && !error, "R9", "zero length done", {done, error}, 2);
        chk(txn_cnt == t0, "R9", "no traffic on zero length", txn_cnt - t0, 0);

        // R10: start during a run is ignored
        busy_polls = 2;
        plan_range(256 * 2, 256 * 10, 256, 8);
        pulse_start(256 * 2, 256 * 10, 256, 8);
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R10", "still busy at second start", busy, 1);
        pulse_start(256 * 3, 256, 264, 9);
        wait_idle();
        chk(done && exp_q.size() == 0, "R10", "only first request issued", exp_q.size(), 0);

        // R8: device never ready -> timeout, no second command
        never_ready = 1'b1;
        plan_range(0, 256, 256, 8);
        run_op(0, 256 * 2, 256, 8);
        chk(error && !done, "R8", "timeout raises error", {done, error}, 1);
        chk(exp_q.size() == 0 && !busy, "R8", "aborted after first command", exp_q.size(), 0);
        never_ready = 1'b0;

        // R9: flags cleared on next accepted start
        busy_polls = 0;
        plan_range(256, 256, 256, 8);
        run_op(256, 256, 256, 8);
        chk(done && !error, "R9", "error cleared by new start", {done, error}, 2);

        summary();
        $finish;
    end
endmodule